// File: doc/BRIEF.md
# Byte-Wide Three-Wire Serial Port

This block moves one byte at a time over three wires: a serial data input, a serial data output and a serial clock. It acts as the clock source when set to master and follows an external clock when set to slave. A processor reaches it through three byte registers: control at address 0, status at address 1 and data at address 2. Address 3 reads as zero. In master mode, writing the data register while the port is idle loads the byte and starts the transfer. The port then produces eight clock periods and stops.

The clock idles high. The outgoing bit changes on each falling clock edge and the incoming bit is captured on each rising edge. After the eighth rising edge the completion flag is set, and it can raise an interrupt. The received byte can then be read from the data register. Any access to the data register while a transfer is running is refused and sets a collision flag. Both flags are cleared by a two-step sequence: first a status read that sees a flag set, then any access to the data register.

Top module: `spi3_port`

## Requirements
- R1: The clock output enable `sck_oe` is 1 exactly when control bit 3 (enable) and control bit 2 (master) are both 1.
- R2: In master mode with enable set, a write to address 2 while idle loads the written byte and starts a transfer.
- R3: After eight clock periods the master clock stays high and status bit 7 (completion) is set.
- R4: `irq` equals status bit 7 ANDed with control bit 4 (interrupt enable).
- R5: Control bit 1 picks the bit order: 0 sends and receives the most significant bit first, and 1 sends and receives the least significant bit first. The received byte reads back from address 2.
- R6: Control bit 0 picks the master clock rate. With 0 the period is 4 system clocks and with 1 it is 32. The first falling edge comes half a period after the starting write.
- R7: A read or a write of address 2 during a transfer sets status bit 6 (collision). Such a write changes neither the transfer nor the shifted data.
- R8: Control bits 7 to 5 are reserved and always read as 0.
- R9: The output bit changes only on a falling clock edge, the input is captured on a rising edge, and the clock is high whenever no transfer is running.
- R10: A status read that sees bit 7 or bit 6 set, followed by an access to address 2, clears both flags. An access to address 2 without that status read leaves the flags unchanged.
- R11: In slave mode (enable set, master clear), the port shifts on the synchronised `sck_in`. Completion is set after the eighth rising edge and not earlier.
- R12: After reset, control and status read 0, `sck_out` and `sdo` are 1, and `irq` and `sck_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (carries side effects) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the current address |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sck_in | input | 1 | External serial clock for slave mode |
| sck_out | output | 1 | Serial clock produced in master mode |
| sck_oe | output | 1 | High when `sck_out` should drive the clock wire |
| irq | output | 1 | Completion interrupt request |

## Verification
The bound checker tests on every cycle that a data write in idle master mode starts a transfer, and that any data access during a transfer raises the collision flag. It also tests that completion coincides with the end of the busy state, that the clearing sequence empties both flags, and that the clock sits high outside a transfer. Only the bench scenarios can show the exact clock period at each rate, the bit order on both wires, that a colliding write leaves the received byte intact, and that slave completion waits for the eighth external edge. The bench model follows the clock and the interrupt cycle by cycle.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;

   localparam int STAT_DONE_BIT = 7;
   localparam int STAT_COL_BIT  = 6;

   // packed so that slow lands on bit 0 and irq_en on bit 4
   typedef struct packed {
      logic irq_en;
      logic enable;
      logic master;
      logic lsb_first;
      logic slow;
   } ctrl_t;
endpackage

// File: rtl/spi3_rate_gen.sv
module spi3_rate_gen #(
   parameter int DIV_FAST = 4,
   parameter int DIV_SLOW = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic slow,
   output logic tick
);
   localparam int HALF_F = DIV_FAST / 2;
   localparam int HALF_S = DIV_SLOW / 2;
   localparam int CW     = (HALF_S > 1) ? $clog2(HALF_S) : 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   assign last = slow ? CW'(HALF_S - 1) : CW'(HALF_F - 1);
   assign tick = run && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt == last) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi3_sck_sync.sv
module spi3_sck_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b1;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~prev;
   assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/spi3_shifter.sv
module spi3_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              restart,
   input  logic              drive,
   input  logic              sample,
   input  logic              lsb_first,
   input  logic              sdi,
   output logic              sdo,
   output logic [DATA_W-1:0] data,
   output logic              at_last
);
   localparam int BW = $clog2(DATA_W);

   logic [DATA_W-1:0] sr;
   logic [BW-1:0]     bitn;

   assign data    = sr;
   assign at_last = (bitn == BW'(DATA_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         bitn <= '0;
         sdo  <= 1'b1;
      end else begin
         if (load) begin
            sr   <= load_val;
            bitn <= '0;
         end else if (restart) begin
            bitn <= '0;
         end else if (sample) begin
            sr   <= lsb_first ? {sdi, sr[DATA_W-1:1]} : {sr[DATA_W-2:0], sdi};
            bitn <= bitn + 1'b1;
         end
         if (drive) sdo <= lsb_first ? sr[0] : sr[DATA_W-1];
      end
   end
endmodule

// File: rtl/spi3_port.sv
module spi3_port
   import spi3_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_FAST    = 4,
   parameter int DIV_SLOW    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              sdi,
   output logic              sdo,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   output logic              irq
);
   localparam int CTRL_W = $bits(ctrl_t);

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end
   if (DIV_FAST < 2 || (DIV_FAST % 2) != 0 || DIV_SLOW < DIV_FAST || (DIV_SLOW % 2) != 0) begin : g_bad_div
      $error("dividers must be even and DIV_SLOW >= DIV_FAST");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   ctrl_t ctrl_q;
   logic  busy, sck_q, done_f, col_f, armed;
   logic  tick, s_rise, s_fall, at_last;
   logic  [DATA_W-1:0] sh_data;

   logic data_acc, data_wr, load, start_m, master_on, slave_on;
   logic slave_start, drive, sample, finish, clr;

   assign master_on   = ctrl_q.enable & ctrl_q.master;
   assign slave_on    = ctrl_q.enable & ~ctrl_q.master;
   assign data_acc    = (reg_wr | reg_rd) && (reg_addr == ADDR_DATA);
   assign data_wr     = reg_wr && (reg_addr == ADDR_DATA);
   assign load        = data_wr & ~busy;
   assign start_m     = load & master_on;
   assign slave_start = slave_on & s_fall & ~busy;
   assign drive       = (tick & sck_q) | (slave_on & s_fall);
   assign sample      = (tick & ~sck_q) | (slave_on & busy & s_rise);
   assign finish      = sample & at_last;
   assign clr         = armed & data_acc;

   spi3_rate_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_rate (
      .clk(clk), .rst_n(rst_n), .run(busy & ctrl_q.master), .slow(ctrl_q.slow), .tick(tick));

   spi3_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(sck_in), .rise(s_rise), .fall(s_fall));

   spi3_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(reg_wdata),
      .restart(slave_start), .drive(drive), .sample(sample),
      .lsb_first(ctrl_q.lsb_first), .sdi(sdi), .sdo(sdo),
      .data(sh_data), .at_last(at_last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         busy   <= 1'b0;
         sck_q  <= 1'b1;
         done_f <= 1'b0;
         col_f  <= 1'b0;
         armed  <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);

         if (!ctrl_q.enable)                  busy <= 1'b0;
         else if (finish)                     busy <= 1'b0;
         else if (start_m || slave_start)     busy <= 1'b1;

         if (!master_on)  sck_q <= 1'b1;
         else if (tick)   sck_q <= ~sck_q;
         else if (start_m) sck_q <= 1'b1;

         if (clr) armed <= 1'b0;
         else if (reg_rd && reg_addr == ADDR_STAT && (done_f || col_f)) armed <= 1'b1;

         done_f <= (done_f & ~clr) | finish;
         col_f  <= (col_f & ~clr) | (data_acc & busy);
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
         ADDR_STAT: begin
            reg_rdata[STAT_DONE_BIT] = done_f;
            reg_rdata[STAT_COL_BIT]  = col_f;
         end
         ADDR_DATA: reg_rdata = sh_data;
         default:   reg_rdata = '0;
      endcase
   end

   assign sck_out = sck_q;
   assign sck_oe  = master_on;
   assign irq     = done_f & ctrl_q.irq_en;
endmodule

// File: rtl/spi3_port_chk.sv
module spi3_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic       reg_rd,
   input logic [1:0] reg_addr,
   input logic       sck_out,
   input logic       busy,
   input logic       done_f,
   input logic       col_f,
   input logic       armed,
   input logic       ctl_en,
   input logic       ctl_master
);
   logic dacc;
   assign dacc = (reg_wr || reg_rd) && (reg_addr == 2'd2);

   AST_MASTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd2 && !busy && ctl_en && ctl_master) |=> busy); // R2
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_f) |-> $fell(busy)); // R3
   AST_COLLISION_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (dacc && busy) |=> col_f); // R7
   AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_out); // R9
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && dacc && !busy) |=> (!done_f && !col_f)); // R10
endmodule

bind spi3_port spi3_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
   .sck_out(sck_out), .busy(busy), .done_f(done_f), .col_f(col_f), .armed(armed),
   .ctl_en(ctrl_q.enable), .ctl_master(ctrl_q.master));

// File: tb/sim_spi3_port.sv
`timescale 1ns/1ps
module sim_spi3_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       sdi = 1'b0, sck_in = 1'b1;
   logic       sdo, sck_out, sck_oe, irq;

   int tests = 0, fails = 0;

   always #2 clk = ~clk;

   spi3_port u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sdi(sdi), .sdo(sdo),
      .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .irq(irq));

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference of the master clock and flags
   int   m_busy = 0, m_cnt = 0, m_edges = 0, m_half = 2;
   bit   m_done = 0, m_col = 0, m_armed = 0, m_sck = 1;
   logic [4:0] m_ctrl = 5'd0;
   bit   cmp_irq = 1;

   always @(posedge clk) begin
      bit dacc, clr, fin, col;
      if (!rst_n) begin
         m_busy = 0; m_cnt = 0; m_edges = 0; m_done = 0; m_col = 0;
         m_armed = 0; m_sck = 1; m_ctrl = 5'd0;
      end else begin
         dacc = (reg_wr || reg_rd) && reg_addr == 2'd2;
         clr  = m_armed && dacc;
         col  = dacc && (m_busy != 0);
         fin  = 0;
         if (m_busy != 0) begin
            m_cnt++;
            if (m_cnt == m_half) begin
               m_cnt = 0;
               m_edges++;
               m_sck = (m_edges % 2 == 0);
               if (m_edges == 16) begin m_busy = 0; fin = 1; end
            end
         end else if (reg_wr && reg_addr == 2'd2 && m_ctrl[3] && m_ctrl[2]) begin
            m_busy = 1; m_cnt = 0; m_edges = 0; m_sck = 1;
            m_half = m_ctrl[0] ? 16 : 2;
         end
         if (clr) m_armed = 0;
         else if (reg_rd && reg_addr == 2'd1 && (m_done || m_col)) m_armed = 1;
         m_done = (m_done && !clr) || fin;
         m_col  = (m_col && !clr) || col;
         if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata[4:0];
      end
   end

   // per-cycle comparison and master serial data handling
   logic [7:0] tx_b, rx_b;
   bit   lsb_b;
   int   bi = 0;
   logic prev_sck = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R6 R9 sck_out per cycle", sck_out, m_sck);
         if (cmp_irq) chk("R4 irq per cycle", irq, m_done && m_ctrl[4]);
         if (prev_sck && !sck_out && m_busy != 0) begin
            chk("R5 R9 sdo after falling edge", sdo, lsb_b ? tx_b[bi] : tx_b[7-bi]);
            sdi = lsb_b ? rx_b[bi] : rx_b[7-bi];
            bi++;
         end
      end
      prev_sck = sck_out;
   end

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      while (m_busy != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      rd_reg(2'd0, d); chk("R12 ctrl after reset", d, 8'h00);
      rd_reg(2'd1, d); chk("R12 status after reset", d, 8'h00);
      chk("R12 sck_out after reset", sck_out, 1);
      chk("R12 sdo after reset", sdo, 1);
      chk("R12 irq after reset", irq, 0);
      chk("R12 sck_oe after reset", sck_oe, 0);

      // R8 reserved bits, R1 output enable
      wr_reg(2'd0, 8'hEC);
      rd_reg(2'd0, d); chk("R8 reserved control bits read 0", d, 8'h0C);
      chk("R1 sck_oe in master", sck_oe, 1);

      // R2 R3 R5 R6: fast, MSB first
      tx_b = 8'hA5; rx_b = 8'h3C; lsb_b = 0; bi = 0;
      wr_reg(2'd2, tx_b);
      wait_idle();
      chk("R3 eight bits shifted", bi, 8);
      chk("R3 clock high after transfer", sck_out, 1);
      rd_reg(2'd2, d); chk("R5 MSB-first received byte", d, 8'h3C);
      rd_reg(2'd1, d); chk("R10 flag kept without status read first", d, 8'h80);
      rd_reg(2'd2, d);
      rd_reg(2'd1, d); chk("R10 flags cleared by sequence", d, 8'h00);

      // R4 R5 R6 R7: slow, LSB first, interrupt on, collisions
      wr_reg(2'd0, 8'h1F);
      tx_b = 8'h13; rx_b = 8'hC8; lsb_b = 1; bi = 0;
      wr_reg(2'd2, tx_b);
      repeat (40) @(negedge clk);
      rd_reg(2'd2, d);
      wr_reg(2'd2, 8'hFF);
      chk("R4 irq low during transfer", irq, 0);
      wait_idle();
      chk("R6 R7 eight bits despite colliding write", bi, 8);
      chk("R4 irq after completion", irq, 1);
      rd_reg(2'd1, d); chk("R7 completion and collision flags", d, 8'hC0);
      rd_reg(2'd2, d); chk("R5 R7 LSB-first byte unaffected by write", d, 8'hC8);
      rd_reg(2'd1, d); chk("R10 flags cleared", d, 8'h00);
      chk("R4 irq cleared", irq, 0);

      // R11 slave mode
      cmp_irq = 0;
      wr_reg(2'd0, 8'h08);
      chk("R1 sck_oe low in slave", sck_oe, 0);
      wr_reg(2'd2, 8'h5A);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); sck_in = 1'b0;
         repeat (5) @(negedge clk);
         chk("R11 slave sdo bit", sdo, 8'h5A >> (7 - i) & 1);
         sdi = (8'hB1 >> (7 - i)) & 1;
         if (i == 7) begin
            rd_reg(2'd1, d); chk("R11 no completion before eighth edge", d, 8'h00);
         end
         @(negedge clk); sck_in = 1'b1;
         repeat (5) @(negedge clk);
      end
      rd_reg(2'd1, d); chk("R11 slave completion", d, 8'h80);
      rd_reg(2'd2, d); chk("R11 slave received byte", d, 8'hB1);
      chk("R11 sck_out stays high in slave", sck_out, 1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule